// File: doc/BRIEF.md
# Nested Fault Escalation Classifier

This block sits beside a processor's exception entry path and decides what a newly raised exception turns into, given the exception whose delivery is still in flight. Each vector is sorted into one of four classes: contributory (vector 0 and vectors 10 through 13), page fault (vector 14), double fault (vector 8), or benign (all other vectors). The pair formed by the pending class and the new class decides the result. The new exception is either delivered as is, turned into a double fault with a zero error code, or, when a double fault is already pending, replaced by a shutdown request.

The block holds the pending-exception register. A raise strobe carries a 5-bit vector, an error code and a flag that marks software interrupts. Software interrupts skip the whole check. A clear strobe tells the block that delivery finished, and it returns the register to its idle code (all ones, which no rule treats as pending). A guest-intercept input turns the shutdown into a shutdown-type virtualization-exit request. The results appear on registered outputs one clock after the raise.

Top module: `nested_fault_classifier`

## Requirements
- R1: After reset the pending register holds the idle code (all ones), and every output is 0.
- R2: A non-software raise of a contributory vector (0, 10, 11, 12 or 13) while a contributory vector is pending is delivered as vector 8 with error code 0.
- R3: A non-software raise of a contributory vector or of vector 14 while vector 14 is pending is delivered as vector 8 with error code 0.
- R4: A non-software raise of any vector while vector 8 is pending produces no delivery. Instead it pulses shutdown_o, or vexit_o when guest_icpt_i is 1 (and the variant has that path). The pending register is left as it was.
- R5: After a non-software delivery, the pending register takes the final vector if that vector is contributory, 14 or 8. A benign final vector leaves the register unchanged.
- R6: A raise with sw_int_i=1 delivers its vector and error code unchanged. It never escalates or shuts down, and it does not touch the pending register.
- R7: Escalation happens only in the cases of R2, R3 and R4. A benign pending vector, a benign new vector, or a page fault raised over a contributory vector is delivered unchanged.
- R8: clear_i alone returns the pending register to the idle code. When raise_i and clear_i are both 1 in the same cycle, the raise is processed and the clear is ignored.
- R9: Outputs register the decision one clock after raise_i. Each pulse lasts one cycle. out_vec_o and out_err_o are 0 whenever out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | Exception raise strobe |
| vec_i | input | VEC_W | Raised vector number |
| err_i | input | ERR_W | Raised error code |
| sw_int_i | input | 1 | Raise comes from a software interrupt |
| guest_icpt_i | input | 1 | Guest intercept mode: shutdown becomes a virtualization exit |
| clear_i | input | 1 | Delivery finished; pending register returns to idle |
| out_valid_o | output | 1 | Delivery decision valid (one-cycle pulse) |
| out_vec_o | output | VEC_W | Final vector to deliver |
| out_err_o | output | ERR_W | Final error code |
| shutdown_o | output | 1 | Shutdown/reset request pulse |
| vexit_o | output | 1 | Shutdown-type virtualization-exit request pulse |

## Verification
The bench targets the asymmetric pairs:
- A page fault over a contributory fault must pass through unchanged. A design that treats the pair symmetrically would emit vector 8 there.
- A contributory fault over a page fault must escalate. A design that treats the pair symmetrically would deliver it unchanged there.
- A benign delivery while a fault is pending must not overwrite the register. A design that did would lose a later escalation.
- A software interrupt raised while a double fault is pending must not trigger shutdown.
- A simultaneous raise and clear must not drop the pending state. A design that let the clear win would let a later fault through instead of shutting down.

Long random runs against the behavioural model cover the other class pairs.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   typedef enum logic [1:0] {
      FC_BENIGN  = 2'd0,
      FC_CONTRIB = 2'd1,
      FC_PAGE    = 2'd2,
      FC_DOUBLE  = 2'd3
   } fault_cls_e;

endpackage

// File: rtl/nfc_vec_classify.sv
module nfc_vec_classify #(
   parameter int VEC_W      = 5,
   parameter int DIV_VEC    = 0,
   parameter int CONTRIB_LO = 10,
   parameter int CONTRIB_HI = 13,
   parameter int PF_VEC     = 14,
   parameter int DF_VEC     = 8
) (
   input  logic [VEC_W-1:0]   vec_i,
   output nfc_pkg::fault_cls_e cls_o
);
   localparam logic [VEC_W-1:0] DIV_V = VEC_W'(DIV_VEC);
   localparam logic [VEC_W-1:0] LO_V  = VEC_W'(CONTRIB_LO);
   localparam logic [VEC_W-1:0] HI_V  = VEC_W'(CONTRIB_HI);
   localparam logic [VEC_W-1:0] PF_V  = VEC_W'(PF_VEC);
   localparam logic [VEC_W-1:0] DF_V  = VEC_W'(DF_VEC);

   always_comb begin
      if (vec_i == DF_V)
         cls_o = nfc_pkg::FC_DOUBLE;
      else if (vec_i == PF_V)
         cls_o = nfc_pkg::FC_PAGE;
      else if ((vec_i == DIV_V) || ((vec_i >= LO_V) && (vec_i <= HI_V)))
         cls_o = nfc_pkg::FC_CONTRIB;
      else
         cls_o = nfc_pkg::FC_BENIGN;
   end
endmodule

// File: rtl/nfc_escalate.sv
module nfc_escalate #(
   parameter bit VEXIT_EN = 1'b1
) (
   input  logic                fire_i,
   input  logic                icpt_i,
   input  nfc_pkg::fault_cls_e pend_cls_i,
   input  nfc_pkg::fault_cls_e new_cls_i,
   output logic                to_double_o,
   output logic                halt_o,
   output logic                halt_shut_o,
   output logic                halt_vexit_o
);
   import nfc_pkg::*;

   logic pair_cc;
   logic pair_pf;

   assign pair_cc = (pend_cls_i == FC_CONTRIB) && (new_cls_i == FC_CONTRIB);
   assign pair_pf = (pend_cls_i == FC_PAGE) &&
                    ((new_cls_i == FC_CONTRIB) || (new_cls_i == FC_PAGE));

   assign halt_o      = fire_i && (pend_cls_i == FC_DOUBLE);
   assign to_double_o = fire_i && !halt_o && (pair_cc || pair_pf);

   if (VEXIT_EN) begin : g_vexit
      assign halt_vexit_o = halt_o && icpt_i;
      assign halt_shut_o  = halt_o && !icpt_i;
   end else begin : g_no_vexit
      logic unused_icpt;
      assign unused_icpt  = icpt_i;
      assign halt_vexit_o = 1'b0;
      assign halt_shut_o  = halt_o;
   end
endmodule

// File: rtl/nfc_pend_reg.sv
module nfc_pend_reg #(
   parameter int VEC_W = 5
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                raise_i,
   input  logic                sw_int_i,
   input  logic                halt_i,
   input  logic                clear_i,
   input  logic [VEC_W-1:0]    fin_vec_i,
   input  nfc_pkg::fault_cls_e fin_cls_i,
   output logic [VEC_W-1:0]    pend_q_o
);
   localparam logic [VEC_W-1:0] IDLE_V = {VEC_W{1'b1}};

   logic [VEC_W-1:0] pend_q;
   logic             take;

   assign take = raise_i && !sw_int_i && !halt_i &&
                 (fin_cls_i != nfc_pkg::FC_BENIGN);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pend_q <= IDLE_V;
      else if (raise_i) begin
         if (take)
            pend_q <= fin_vec_i;
      end else if (clear_i)
         pend_q <= IDLE_V;
   end

   assign pend_q_o = pend_q;
endmodule

// File: rtl/nested_fault_classifier.sv
module nested_fault_classifier #(
   parameter int VEC_W      = 5,
   parameter int ERR_W      = 32,
   parameter int DIV_VEC    = 0,
   parameter int CONTRIB_LO = 10,
   parameter int CONTRIB_HI = 13,
   parameter int PF_VEC     = 14,
   parameter int DF_VEC     = 8,
   parameter bit VEXIT_EN   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             raise_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic             sw_int_i,
   input  logic             guest_icpt_i,
   input  logic             clear_i,
   output logic             out_valid_o,
   output logic [VEC_W-1:0] out_vec_o,
   output logic [ERR_W-1:0] out_err_o,
   output logic             shutdown_o,
   output logic             vexit_o
);
   import nfc_pkg::*;

   localparam int               VEC_MAX = (1 << VEC_W) - 1;
   localparam logic [VEC_W-1:0] DF_V    = VEC_W'(DF_VEC);

   if (VEC_W < 4 || VEC_W > 8) begin : g_bad_vec_w
      $error("VEC_W must lie in 4..8");
   end
   if (ERR_W < 1) begin : g_bad_err_w
      $error("ERR_W must be positive");
   end
   if (CONTRIB_LO > CONTRIB_HI || CONTRIB_HI >= VEC_MAX) begin : g_bad_range
      $error("contributory range invalid or covers the idle code");
   end
   if (PF_VEC >= VEC_MAX || DF_VEC >= VEC_MAX || DIV_VEC >= VEC_MAX) begin : g_bad_special
      $error("special vectors must differ from the idle code");
   end
   if (PF_VEC == DF_VEC) begin : g_bad_alias
      $error("page-fault and double-fault vectors must differ");
   end

   fault_cls_e       new_cls;
   fault_cls_e       pend_cls;
   fault_cls_e       fin_cls;
   logic [VEC_W-1:0] pend_q;
   logic [VEC_W-1:0] fin_vec;
   logic [ERR_W-1:0] fin_err;
   logic             fire;
   logic             to_double;
   logic             halt;
   logic             halt_shut;
   logic             halt_vexit;

   assign fire = raise_i && !sw_int_i;

   nfc_vec_classify #(
      .VEC_W(VEC_W), .DIV_VEC(DIV_VEC), .CONTRIB_LO(CONTRIB_LO),
      .CONTRIB_HI(CONTRIB_HI), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)
   ) u_cls_new (
      .vec_i (vec_i),
      .cls_o (new_cls)
   );

   nfc_vec_classify #(
      .VEC_W(VEC_W), .DIV_VEC(DIV_VEC), .CONTRIB_LO(CONTRIB_LO),
      .CONTRIB_HI(CONTRIB_HI), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)
   ) u_cls_pend (
      .vec_i (pend_q),
      .cls_o (pend_cls)
   );

   nfc_escalate #(
      .VEXIT_EN(VEXIT_EN)
   ) u_esc (
      .fire_i       (fire),
      .icpt_i       (guest_icpt_i),
      .pend_cls_i   (pend_cls),
      .new_cls_i    (new_cls),
      .to_double_o  (to_double),
      .halt_o       (halt),
      .halt_shut_o  (halt_shut),
      .halt_vexit_o (halt_vexit)
   );

   assign fin_vec = to_double ? DF_V : vec_i;
   assign fin_err = to_double ? '0 : err_i;
   assign fin_cls = to_double ? FC_DOUBLE : new_cls;

   nfc_pend_reg #(
      .VEC_W(VEC_W)
   ) u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raise_i   (raise_i),
      .sw_int_i  (sw_int_i),
      .halt_i    (halt),
      .clear_i   (clear_i),
      .fin_vec_i (fin_vec),
      .fin_cls_i (fin_cls),
      .pend_q_o  (pend_q)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         out_vec_o   <= '0;
         out_err_o   <= '0;
         shutdown_o  <= 1'b0;
         vexit_o     <= 1'b0;
      end else begin
         out_valid_o <= raise_i && !halt;
         out_vec_o   <= (raise_i && !halt) ? fin_vec : '0;
         out_err_o   <= (raise_i && !halt) ? fin_err : '0;
         shutdown_o  <= halt_shut;
         vexit_o     <= halt_vexit;
      end
   end
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
   parameter int VEC_W      = 5,
   parameter int ERR_W      = 32,
   parameter int DIV_VEC    = 0,
   parameter int CONTRIB_LO = 10,
   parameter int CONTRIB_HI = 13,
   parameter int PF_VEC     = 14,
   parameter int DF_VEC     = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             raise_i,
   input logic [VEC_W-1:0] vec_i,
   input logic [ERR_W-1:0] err_i,
   input logic             sw_int_i,
   input logic             clear_i,
   input logic [VEC_W-1:0] pend_q,
   input logic             out_valid_o,
   input logic [VEC_W-1:0] out_vec_o,
   input logic [ERR_W-1:0] out_err_o,
   input logic             shutdown_o,
   input logic             vexit_o
);
   function automatic logic is_contrib(input logic [VEC_W-1:0] v);
      return (int'(v) == DIV_VEC) || (int'(v) >= CONTRIB_LO && int'(v) <= CONTRIB_HI);
   endfunction

   logic hard_raise;
   assign hard_raise = raise_i && !sw_int_i;

   AST_RESET_IDLE: assert property (@(posedge clk_i) $rose(rst_ni) |-> (&pend_q)) // R1
      else $error("pending not idle after reset");

   AST_CONTRIB_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_raise && is_contrib(pend_q) && is_contrib(vec_i)
      |=> out_valid_o && out_vec_o == VEC_W'(DF_VEC) && out_err_o == '0) // R2
      else $error("contributory pair did not escalate");

   AST_PAGE_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_raise && int'(pend_q) == PF_VEC && (is_contrib(vec_i) || int'(vec_i) == PF_VEC)
      |=> out_valid_o && out_vec_o == VEC_W'(DF_VEC) && out_err_o == '0) // R3
      else $error("page-fault pair did not escalate");

   AST_HALT_NO_DELIVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_raise && int'(pend_q) == DF_VEC
      |=> !out_valid_o && (shutdown_o != vexit_o) && int'(pend_q) == DF_VEC) // R4
      else $error("double-fault pending raise mishandled");

   AST_SW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise_i && sw_int_i
      |=> out_valid_o && !shutdown_o && !vexit_o && out_vec_o == $past(vec_i)
          && out_err_o == $past(err_i) && pend_q == $past(pend_q)) // R6
      else $error("software interrupt altered");

   AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i && !raise_i |=> (&pend_q)) // R8
      else $error("clear did not restore idle");

   AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !raise_i |=> !out_valid_o && !shutdown_o && !vexit_o
                   && out_vec_o == '0 && out_err_o == '0) // R9
      else $error("output without raise");

   AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise_i |=> $countones({out_valid_o, shutdown_o, vexit_o}) == 1) // R9
      else $error("raise without exactly one result");
endmodule

bind nested_fault_classifier nfc_checker #(
   .VEC_W(VEC_W), .ERR_W(ERR_W), .DIV_VEC(DIV_VEC), .CONTRIB_LO(CONTRIB_LO),
   .CONTRIB_HI(CONTRIB_HI), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)
) u_nfc_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .raise_i     (raise_i),
   .vec_i       (vec_i),
   .err_i       (err_i),
   .sw_int_i    (sw_int_i),
   .clear_i     (clear_i),
   .pend_q      (pend_q),
   .out_valid_o (out_valid_o),
   .out_vec_o   (out_vec_o),
   .out_err_o   (out_err_o),
   .shutdown_o  (shutdown_o),
   .vexit_o     (vexit_o)
);

// File: tb/nested_fault_classifier_tb_top.sv
module nested_fault_classifier_tb_top;
   localparam int CLK_P = 10;
   localparam int VW    = 5;
   localparam int EW    = 32;
   localparam int WD    = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          raise = 1'b0;
   logic [VW-1:0] vec = '0;
   logic [EW-1:0] err = '0;
   logic          sw = 1'b0;
   logic          icpt = 1'b0;
   logic          clr = 1'b0;
   logic          o_valid;
   logic [VW-1:0] o_vec;
   logic [EW-1:0] o_err;
   logic          o_shut;
   logic          o_vexit;

   int  tests = 0;
   int  fails = 0;
   int  pend  = 31;
   bit  done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   nested_fault_classifier dut_i (
      .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .vec_i(vec), .err_i(err),
      .sw_int_i(sw), .guest_icpt_i(icpt), .clear_i(clr),
      .out_valid_o(o_valid), .out_vec_o(o_vec), .out_err_o(o_err),
      .shutdown_o(o_shut), .vexit_o(o_vexit)
   );

   function automatic bit contrib(input int v);
      return v == 0 || (v >= 10 && v <= 13);
   endfunction

   task automatic check(input string tag, input bit ev, input int evec, input int eerr,
                        input bit es, input bit ex);
      tests++;
      if (o_valid !== ev || int'(o_vec) !== evec || int'(o_err) !== eerr ||
          o_shut !== es || o_vexit !== ex) begin
         fails++;
         $display("FAIL %s: got valid=%0b vec=%0d err=%0h shut=%0b vexit=%0b, expected valid=%0b vec=%0d err=%0h shut=%0b vexit=%0b",
                  tag, o_valid, o_vec, o_err, o_shut, o_vexit, ev, evec, eerr, es, ex);
      end
   endtask

   // Drive one cycle, predict with the behavioural model, compare after the edge.
   task automatic cyc(input bit r, input int v, input int e, input bit s, input bit ic,
                      input bit c, input string tag);
      bit ev = 0, es = 0, ex = 0;
      int evec = 0, eerr = 0;
      raise = r; vec = VW'(v); err = EW'(e); sw = s; icpt = ic; clr = c;
      if (r) begin
         if (s) begin
            ev = 1; evec = v; eerr = e;
         end else if (pend == 8) begin
            if (ic) ex = 1; else es = 1;
         end else begin
            int fv = v;
            int fe = e;
            if ((contrib(pend) && contrib(v)) || (pend == 14 && (contrib(v) || v == 14))) begin
               fv = 8; fe = 0;
            end
            ev = 1; evec = fv; eerr = fe;
            if (contrib(fv) || fv == 14 || fv == 8) pend = fv;
         end
      end else if (c) begin
         pend = 31;
      end
      @(posedge clk);
      #(CLK_P/4);
      check(tag, ev, evec, eerr, es, ex);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic clear_pend();
      cyc(0, 0, 0, 0, 0, 1, "R8");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      check("R1 in reset", 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      idle("R1 after reset");

      cyc(1, 13, 5, 0, 0, 0, "R5 contrib delivered");
      cyc(1, 0, 'h33, 0, 0, 0, "R2 contrib on contrib");
      cyc(1, 3, 1, 0, 0, 0, "R4 shutdown");
      cyc(1, 6, 1, 0, 1, 0, "R4 vexit");
      cyc(1, 3, 7, 1, 0, 0, "R6 sw over double");
      cyc(1, 11, 2, 0, 0, 1, "R8 raise beats clear");
      clear_pend();
      cyc(1, 11, 'h44, 0, 0, 0, "R8 idle after clear");
      clear_pend();

      cyc(1, 14, 6, 0, 0, 0, "R5 page fault delivered");
      cyc(1, 14, 2, 0, 0, 0, "R3 pf on pf");
      clear_pend();
      cyc(1, 14, 6, 0, 0, 0, "R5 pf");
      cyc(1, 10, 9, 0, 0, 0, "R3 contrib on pf");
      clear_pend();

      cyc(1, 10, 1, 0, 0, 0, "R5 contrib");
      cyc(1, 14, 4, 0, 0, 0, "R7 pf on contrib passes");
      cyc(1, 12, 3, 0, 0, 0, "R3 contrib on pf");
      clear_pend();

      cyc(1, 2, 1, 0, 0, 0, "R7 benign on idle");
      cyc(1, 13, 8, 0, 0, 0, "R7 contrib on benign");
      cyc(1, 1, 9, 0, 0, 0, "R5 benign keeps pending");
      cyc(1, 11, 5, 0, 0, 0, "R5 pending survived benign");
      clear_pend();

      cyc(1, 13, 'hAB, 1, 0, 0, "R6 sw no pending update");
      cyc(1, 10, 'hCD, 0, 0, 0, "R6 followup delivered");
      clear_pend();
      idle("R9 quiet");
      idle("R9 quiet");

      for (int i = 0; i < 2000; i++) begin
         int  rv  = $urandom_range(0, 31);
         bit  rr  = ($urandom_range(0, 3) != 0);
         bit  rs  = ($urandom_range(0, 7) == 0);
         bit  ric = $urandom_range(0, 1);
         bit  rc  = ($urandom_range(0, 5) == 0);
         if (rv > 15 && $urandom_range(0, 1) == 1) rv = rv - 16;
         cyc(rr, rv, int'($urandom), rs, ric, rc, "R9 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule